// File: doc/BRIEF.md
# Bit-Serial Broadcast-Instruction Processing Element

This block is one processing element of a two-dimensional array in which every element executes the same instruction in the same clock cycle. The element keeps four one-bit registers, a 128-entry one-bit local store and a fixed full adder/subtracter. The adder/subtracter has no opcode and evaluates every cycle. The four registers are:

- V, the north-south neighbour register.
- H, the east-west neighbour register.
- K, the carry/borrow register.
- X, a transfer register that shifts data northward.

All computation comes from routing. Each instruction chooses one source for each register and one source for the store's write port. To obtain logic functions, one adder input is forced to a constant.

Multi-bit arithmetic runs one bit per step over consecutive store addresses, with K holding the carry or borrow between steps. An external sequencer, outside this block, supplies the 20-bit instruction every cycle. The array wiring is also outside this block. It connects the V, H and X outputs of each element to the matching inputs of its neighbours.

Instruction layout, most significant field first:

| Bits | Field |
|---|---|
| [19:17] | store-write source (W) |
| [16:15] | X source |
| [14:13] | K source |
| [12:10] | H source |
| [9:7] | V source |
| [6:0] | store address |

Top module: `bsp_pe`

## Requirements
- R1: While `rst_ni` is low, V, H, K and X clear to 0 asynchronously, so `vert_o`, `horiz_o` and `xfer_o` read 0 after reset.
- R2: With V source code 6, V takes the sum bit, which is V xor H xor K, formed from the values held before the edge.
- R3: With K source code 1, K takes the carry, which is the majority of V, H and K.
- R4: With K source code 2, K takes the borrow of V − H − K. The borrow is 1 exactly when (V,H,K) is 010, 001, 011 or 111.
- R5: V source codes in bits [9:7] are as follows:
  - 0: hold
  - 1: `vert_n_i`
  - 2: `vert_s_i`
  - 3: store read
  - 4: constant 0
  - 5: constant 1
  - 6: sum
  - 7: carry
- R6: H source codes in bits [12:10] are as follows:
  - 0: hold
  - 1: `horiz_e_i`
  - 2: `horiz_w_i`
  - 3: store read
  - 4: constant 0
  - 5: constant 1
  - 6: sum
  - 7: carry
- R7: X source codes in bits [16:15] are as follows:
  - 0: hold
  - 1: `xfer_s_i`
  - 2: store read
  - 3: clear
- R8: Store-write codes in bits [19:17] are as follows. The written address is bits [6:0].
  - 0: no write
  - 1: sum
  - 2: carry
  - 3: borrow
  - 4: X
  - 5: K
  - 6: H
  - 7: V
- R9: In a cycle with a non-zero write code, every store-read selection returns 0. With write code 0, the store is left unchanged.
- R10: One source may feed several destinations in the same cycle. All destinations update together from values sampled before the edge, so a store write of V sees the old V while V is being reloaded.
- R11: A sequence of V-load, H-load, then "K carry plus write sum" steps per bit position adds two multi-bit operands held at consecutive store addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 20 | Broadcast instruction |
| vert_n_i | input | 1 | V of the north neighbour |
| vert_s_i | input | 1 | V of the south neighbour |
| horiz_e_i | input | 1 | H of the east neighbour |
| horiz_w_i | input | 1 | H of the west neighbour |
| xfer_s_i | input | 1 | X of the south neighbour |
| vert_o | output | 1 | V register, to the north and south neighbours |
| horiz_o | output | 1 | H register, to the east and west neighbours |
| xfer_o | output | 1 | X register, to the north neighbour |

## Verification
The bound checker checks these behaviours on every cycle:

- The hold code leaves V and H unchanged.
- The sum, carry and borrow relations hold into V and K against the values sampled one cycle earlier.
- X follows its south input or clears.
- A store-read selection in a writing cycle yields 0.

Only the bench's scenarios can show the following:

- Store contents and address decoding, which are visible only after a write and a later read-back.
- Correct fan-out of one source to several destinations in the same cycle.
- The end-to-end multi-bit addition over a sequence of steps.

A bench reference model tracks all state, including the store, through long random instruction streams.

// File: rtl/bsp_pe_pkg.sv
package bsp_pe_pkg;
  localparam int unsigned ROUTE_W = 13;

  typedef enum logic [2:0] {
    V_HOLD, V_NORTH, V_SOUTH, V_MEM, V_ZERO, V_ONE, V_PLUS, V_CARRY
  } vsrc_e;

  typedef enum logic [2:0] {
    H_HOLD, H_EAST, H_WEST, H_MEM, H_ZERO, H_ONE, H_PLUS, H_CARRY
  } hsrc_e;

  typedef enum logic [1:0] {K_HOLD, K_CARRY, K_BORROW, K_MEM} ksrc_e;

  typedef enum logic [1:0] {X_HOLD, X_SOUTH, X_MEM, X_CLEAR} xsrc_e;

  typedef enum logic [2:0] {
    W_NONE, W_PLUS, W_CARRY, W_BORROW, W_XFER, W_K, W_H, W_V
  } wsrc_e;

  // Field order, MSB first, sits directly above the address bits
  typedef struct packed {
    wsrc_e w_sel;
    xsrc_e x_sel;
    ksrc_e k_sel;
    hsrc_e h_sel;
    vsrc_e v_sel;
  } route_t;

  typedef struct packed {
    logic plus;
    logic carry;
    logic borrow;
  } alu_t;
endpackage

// File: rtl/bsp_pe_alu.sv
module bsp_pe_alu
  import bsp_pe_pkg::*;
(
  input  logic v_i,
  input  logic h_i,
  input  logic k_i,
  output alu_t res_o
);
  always_comb begin
    res_o.plus   = v_i ^ h_i ^ k_i;
    res_o.carry  = (v_i & h_i) | (v_i & k_i) | (h_i & k_i);
    res_o.borrow = (~v_i & h_i) | (~v_i & k_i) | (h_i & k_i);
  end
endmodule

// File: rtl/bsp_pe_mem.sv
module bsp_pe_mem #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic              rdata_o
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk_i) begin
    if (we_i) bits_q[addr_i] <= wdata_i;
  end

  assign rdata_o = bits_q[addr_i];
endmodule

// File: rtl/bsp_pe_regs.sv
module bsp_pe_regs
  import bsp_pe_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  route_t route_i,
  input  alu_t   alu_i,
  input  logic   rd_i,
  input  logic   vert_n_i,
  input  logic   vert_s_i,
  input  logic   horiz_e_i,
  input  logic   horiz_w_i,
  input  logic   xfer_s_i,
  output logic   v_q_o,
  output logic   h_q_o,
  output logic   k_q_o,
  output logic   x_q_o
);
  logic v_d, h_d, k_d, x_d;

  always_comb begin
    unique case (route_i.v_sel)
      V_HOLD:  v_d = v_q_o;
      V_NORTH: v_d = vert_n_i;
      V_SOUTH: v_d = vert_s_i;
      V_MEM:   v_d = rd_i;
      V_ZERO:  v_d = 1'b0;
      V_ONE:   v_d = 1'b1;
      V_PLUS:  v_d = alu_i.plus;
      V_CARRY: v_d = alu_i.carry;
      default: v_d = v_q_o;
    endcase

    unique case (route_i.h_sel)
      H_HOLD:  h_d = h_q_o;
      H_EAST:  h_d = horiz_e_i;
      H_WEST:  h_d = horiz_w_i;
      H_MEM:   h_d = rd_i;
      H_ZERO:  h_d = 1'b0;
      H_ONE:   h_d = 1'b1;
      H_PLUS:  h_d = alu_i.plus;
      H_CARRY: h_d = alu_i.carry;
      default: h_d = h_q_o;
    endcase

    unique case (route_i.k_sel)
      K_HOLD:   k_d = k_q_o;
      K_CARRY:  k_d = alu_i.carry;
      K_BORROW: k_d = alu_i.borrow;
      K_MEM:    k_d = rd_i;
      default:  k_d = k_q_o;
    endcase

    unique case (route_i.x_sel)
      X_HOLD:  x_d = x_q_o;
      X_SOUTH: x_d = xfer_s_i;
      X_MEM:   x_d = rd_i;
      X_CLEAR: x_d = 1'b0;
      default: x_d = x_q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q_o <= 1'b0;
      h_q_o <= 1'b0;
      k_q_o <= 1'b0;
      x_q_o <= 1'b0;
    end else begin
      v_q_o <= v_d;
      h_q_o <= h_d;
      k_q_o <= k_d;
      x_q_o <= x_d;
    end
  end
endmodule

// File: rtl/bsp_pe.sv
module bsp_pe
  import bsp_pe_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned INSTR_W = ROUTE_W + ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               vert_n_i,
  input  logic               vert_s_i,
  input  logic               horiz_e_i,
  input  logic               horiz_w_i,
  input  logic               xfer_s_i,
  output logic               vert_o,
  output logic               horiz_o,
  output logic               xfer_o
);
  route_t            route;
  logic [ADDR_W-1:0] addr;
  alu_t              alu;
  logic              v_q, h_q, k_q, x_q;
  logic              we, wdata, rdata, rd_eff;

  assign route = route_t'(instr_i[INSTR_W-1:ADDR_W]);
  assign addr  = instr_i[ADDR_W-1:0];
  assign we    = (route.w_sel != W_NONE);

  // Single port: a writing cycle has no read
  assign rd_eff = we ? 1'b0 : rdata;

  always_comb begin
    unique case (route.w_sel)
      W_PLUS:   wdata = alu.plus;
      W_CARRY:  wdata = alu.carry;
      W_BORROW: wdata = alu.borrow;
      W_XFER:   wdata = x_q;
      W_K:      wdata = k_q;
      W_H:      wdata = h_q;
      W_V:      wdata = v_q;
      default:  wdata = 1'b0;
    endcase
  end

  bsp_pe_alu u_alu (
    .v_i  (v_q),
    .h_i  (h_q),
    .k_i  (k_q),
    .res_o(alu)
  );

  bsp_pe_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  bsp_pe_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .route_i  (route),
    .alu_i    (alu),
    .rd_i     (rd_eff),
    .vert_n_i (vert_n_i),
    .vert_s_i (vert_s_i),
    .horiz_e_i(horiz_e_i),
    .horiz_w_i(horiz_w_i),
    .xfer_s_i (xfer_s_i),
    .v_q_o    (v_q),
    .h_q_o    (h_q),
    .k_q_o    (k_q),
    .x_q_o    (x_q)
  );

  assign vert_o  = v_q;
  assign horiz_o = h_q;
  assign xfer_o  = x_q;
endmodule

// File: rtl/bsp_pe_chk.sv
module bsp_pe_chk
  import bsp_pe_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input route_t route,
  input logic   rd_eff,
  input logic   xfer_s_i,
  input logic   v_q,
  input logic   h_q,
  input logic   k_q,
  input logic   x_q
);
  // R2
  sum_into_v_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route.v_sel == V_PLUS |=> v_q == ($past(v_q) ^ $past(h_q) ^ $past(k_q)));

  // R3
  carry_into_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route.k_sel == K_CARRY |=>
      k_q == ($countones({$past(v_q), $past(h_q), $past(k_q)}) >= 2));

  // R4
  borrow_into_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route.k_sel == K_BORROW |=>
      k_q == ((({1'b0, $past(h_q)} + {1'b0, $past(k_q)}) > {1'b0, $past(v_q)})));

  // R5
  v_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route.v_sel == V_HOLD |=> $stable(v_q));

  // R6
  h_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route.h_sel == H_HOLD |=> $stable(h_q));

  // R7
  x_from_south_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route.x_sel == X_SOUTH |=> x_q == $past(xfer_s_i));

  // R7
  x_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route.x_sel == X_CLEAR |=> !x_q);

  // R9
  no_read_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route.w_sel != W_NONE |-> !rd_eff);
endmodule

bind bsp_pe bsp_pe_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .route   (route),
  .rd_eff  (rd_eff),
  .xfer_s_i(xfer_s_i),
  .v_q     (v_q),
  .h_q     (h_q),
  .k_q     (k_q),
  .x_q     (x_q)
);

// File: tb/bsp_pe_tb.sv
module bsp_pe_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] instr = '0;
  logic vn = 0, vs = 0, he = 0, hw = 0, xs = 0;
  logic vo, ho, xo;
  int tests = 0, fails = 0;

  // model state
  logic m_v = 0, m_h = 0, m_k = 0, m_x = 0;
  logic [127:0] m_mem;

  always #10 clk = ~clk;

  bsp_pe u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr),
    .vert_n_i(vn), .vert_s_i(vs), .horiz_e_i(he), .horiz_w_i(hw),
    .xfer_s_i(xs), .vert_o(vo), .horiz_o(ho), .xfer_o(xo)
  );

  function automatic logic [19:0] mk(input logic [2:0] v, input logic [2:0] h,
      input logic [1:0] k, input logic [1:0] x, input logic [2:0] w,
      input logic [6:0] a);
    return {w, x, k, h, v, a};
  endfunction

  function automatic logic f_plus(input logic a, b, c);
    return a ^ b ^ c;
  endfunction
  function automatic logic f_carry(input logic a, b, c);
    return (int'(a) + int'(b) + int'(c)) >= 2;
  endfunction
  function automatic logic f_borrow(input logic a, b, c);
    return (int'(a) - int'(b) - int'(c)) < 0;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [19:0] ins, input logic [4:0] nb, input string tag);
    logic [2:0] vs_, hs_, ws_;
    logic [1:0] ks_, xs_;
    logic [6:0] a;
    logic rd, p, c, b, nv, nh, nk, nx, wd;
    @(negedge clk);
    instr = ins;
    {vn, vs, he, hw, xs} = nb;
    {ws_, xs_, ks_, hs_, vs_, a} = ins;
    p = f_plus(m_v, m_h, m_k);
    c = f_carry(m_v, m_h, m_k);
    b = f_borrow(m_v, m_h, m_k);
    rd = (ws_ != 0) ? 1'b0 : m_mem[a];
    case (vs_)
      0: nv = m_v; 1: nv = vn; 2: nv = vs; 3: nv = rd;
      4: nv = 0; 5: nv = 1; 6: nv = p; default: nv = c;
    endcase
    case (hs_)
      0: nh = m_h; 1: nh = he; 2: nh = hw; 3: nh = rd;
      4: nh = 0; 5: nh = 1; 6: nh = p; default: nh = c;
    endcase
    case (ks_)
      0: nk = m_k; 1: nk = c; 2: nk = b; default: nk = rd;
    endcase
    case (xs_)
      0: nx = m_x; 1: nx = xs; 2: nx = rd; default: nx = 0;
    endcase
    case (ws_)
      1: wd = p; 2: wd = c; 3: wd = b; 4: wd = m_x;
      5: wd = m_k; 6: wd = m_h; default: wd = m_v;
    endcase
    if (ws_ != 0) m_mem[a] = wd;
    m_v = nv; m_h = nh; m_k = nk; m_x = nx;
    @(posedge clk);
    #2;
    tests++;
    if ({vo, ho, xo} !== {m_v, m_h, m_x}) begin
      fails++;
      $display("FAIL %s: actual vhx=%b%b%b expected %b%b%b", tag, vo, ho, xo,
               m_v, m_h, m_x);
    end
  endtask

  // load V,H,K to (a,b,c) using only constants and the carry path
  task automatic set_vhk(input logic a, input logic b, input logic c, input string tag);
    step(mk(c ? 5 : 4, c ? 5 : 4, 0, 0, 0, 0), 5'b0, tag);
    step(mk(a ? 5 : 4, b ? 5 : 4, 1, 0, 0, 0), 5'b0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    m_mem = 'x;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 vert_o", vo, 1'b0);
    chk("R1 horiz_o", ho, 1'b0);
    chk("R1 xfer_o", xo, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: K observed through the store
    step(mk(0, 0, 0, 0, 5, 7'd5), 5'b0, "R1 store K");
    step(mk(3, 0, 0, 0, 0, 7'd5), 5'b0, "R1 K read back");
    chk("R1 K cleared", vo, 1'b0);

    // R8: fill the whole store
    for (int i = 0; i < 128; i++)
      step(mk($urandom_range(4, 5), 0, 0, 0, 7, i[6:0]), 5'b0, "R8 fill");

    // R5: V sources
    step(mk(1, 0, 0, 0, 0, 0), 5'b10000, "R5 V from north");
    step(mk(0, 0, 0, 0, 0, 0), 5'b01111, "R5 V hold");
    step(mk(2, 0, 0, 0, 0, 0), 5'b01000, "R5 V from south");
    step(mk(4, 0, 0, 0, 0, 0), 5'b11111, "R5 V zero");
    step(mk(5, 0, 0, 0, 0, 0), 5'b00000, "R5 V one");
    step(mk(3, 0, 0, 0, 0, 7'd9), 5'b0, "R5 V from store");
    step(mk(7, 0, 0, 0, 0, 0), 5'b0, "R5 V carry");
    // R6: H sources
    step(mk(0, 1, 0, 0, 0, 0), 5'b00100, "R6 H from east");
    step(mk(0, 2, 0, 0, 0, 0), 5'b00010, "R6 H from west");
    step(mk(0, 0, 0, 0, 0, 0), 5'b11111, "R6 H hold");
    step(mk(0, 5, 0, 0, 0, 0), 5'b0, "R6 H one");
    step(mk(0, 6, 0, 0, 0, 0), 5'b0, "R6 H plus");
    step(mk(0, 7, 0, 0, 0, 0), 5'b0, "R6 H carry");
    step(mk(0, 3, 0, 0, 0, 7'd77), 5'b0, "R6 H from store");
    step(mk(0, 4, 0, 0, 0, 0), 5'b0, "R6 H zero");
    // R7: X sources
    step(mk(0, 0, 0, 1, 0, 0), 5'b00001, "R7 X from south");
    step(mk(0, 0, 0, 0, 0, 0), 5'b00000, "R7 X hold");
    step(mk(0, 0, 0, 3, 0, 0), 5'b00001, "R7 X clear");
    step(mk(0, 0, 0, 2, 0, 7'd33), 5'b0, "R7 X from store");

    // R2, R3, R4 over all input combinations
    for (int c = 0; c < 8; c++) begin
      set_vhk(c[2], c[1], c[0], "R2 setup");
      step(mk(6, 0, 0, 0, 0, 0), 5'b0, "R2 V plus");
      set_vhk(c[2], c[1], c[0], "R3 setup");
      step(mk(0, 0, 1, 0, 0, 0), 5'b0, "R3 K carry");
      step(mk(0, 0, 0, 0, 5, 7'd100), 5'b0, "R3 store K");
      step(mk(3, 0, 0, 0, 0, 7'd100), 5'b0, "R3 K read back");
      chk("R3 carry", vo, f_carry(c[2], c[1], c[0]));
      set_vhk(c[2], c[1], c[0], "R4 setup");
      step(mk(0, 0, 2, 0, 3, 7'd101), 5'b0, "R4 K borrow with borrow write");
      step(mk(0, 0, 0, 0, 5, 7'd100), 5'b0, "R4 store K");
      step(mk(3, 0, 0, 0, 0, 7'd100), 5'b0, "R4 K read back");
      chk("R4 borrow", vo, f_borrow(c[2], c[1], c[0]));
      step(mk(3, 0, 0, 0, 0, 7'd101), 5'b0, "R4 borrow write read back");
      chk("R4 borrow write", vo, f_borrow(c[2], c[1], c[0]));
    end

    // R9: read during write sees 0; no-write leaves store intact
    step(mk(5, 0, 0, 0, 0, 0), 5'b0, "R9 setup");
    step(mk(0, 0, 0, 0, 7, 7'd60), 5'b0, "R9 store one");
    step(mk(3, 3, 3, 2, 4, 7'd60), 5'b0, "R9 read during write");
    chk("R9 V read-on-write", vo, 1'b0);
    step(mk(4, 0, 0, 0, 0, 7'd61), 5'b0, "R9 no write");
    step(mk(3, 0, 0, 0, 0, 7'd61), 5'b0, "R9 store unchanged");

    // R10: fan-out and pre-edge sampling
    set_vhk(1, 0, 0, "R10 setup");
    step(mk(6, 6, 0, 0, 7, 7'd62), 5'b0, "R10 fan-out plus");
    chk("R10 H equals V", ho, vo);
    step(mk(3, 0, 0, 0, 0, 7'd62), 5'b0, "R10 old V stored");
    chk("R10 old V", vo, 1'b1);

    // R11: 4-bit add, A at 10..13, B at 20..23, sum at 30..33
    for (int t = 0; t < 4; t++) begin
      logic [3:0] av, bv, sv;
      av = 4'($urandom);
      bv = 4'($urandom);
      if (t == 0) begin av = 4'hF; bv = 4'h1; end
      sv = av + bv;
      for (int i = 0; i < 4; i++) begin
        step(mk(av[i] ? 5 : 4, bv[i] ? 5 : 4, 0, 0, 0, 0), 5'b0, "R11 load");
        step(mk(0, 0, 0, 0, 7, 7'(10 + i)), 5'b0, "R11 store A");
        step(mk(0, 0, 0, 0, 6, 7'(20 + i)), 5'b0, "R11 store B");
      end
      set_vhk(0, 0, 0, "R11 clear K");
      for (int i = 0; i < 4; i++) begin
        step(mk(3, 0, 0, 0, 0, 7'(10 + i)), 5'b0, "R11 V<-A");
        step(mk(0, 3, 0, 0, 0, 7'(20 + i)), 5'b0, "R11 H<-B");
        step(mk(0, 0, 1, 0, 1, 7'(30 + i)), 5'b0, "R11 add bit");
      end
      for (int i = 0; i < 4; i++) begin
        step(mk(3, 0, 0, 0, 0, 7'(30 + i)), 5'b0, "R11 read sum");
        chk("R11 sum bit", vo, sv[i]);
      end
    end

    // Random instruction stream against the model
    for (int n = 0; n < 3000; n++)
      step(20'($urandom), 5'($urandom), "random R2 R3 R4 R5 R6 R7 R8 R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule